// File: doc/BRIEF.md
# Two-Level Opcode ALU with Parity

This block is a single-register-stage arithmetic and logic unit. Each issue presents a control byte and three unsigned operands (A, B and C) together with a valid strobe. The upper nibble of the control byte picks one of ten operator classes: arithmetic, logical, relational, equality, bitwise, reduction, shift, concatenation, replication and conditional select. The next three bits pick the operator inside that class. The block computes a double-width result and an even-parity bit. Both are captured on the clock edge that samples the strobe.

The host drives one operation per cycle, or leaves gaps. The output valid marks the cycle in which a fresh result sits on the output. Between issues the result and parity keep their last values. Results narrower than the output are padded with zeros. Any code outside the defined set yields zero. Divide and modulus by zero give a fixed, known value in place of an undefined one.

Top module: `alu_twolevel`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `parity` are cleared to 0 at that edge.
- R2: `out_valid` is 1 in the cycle after each cycle in which `in_valid` was 1, and 0 otherwise. When `in_valid` is 0, `result` and `parity` keep their values.
- R3: The class is `ctrl[7:4]` and the operator is `ctrl[3:1]`. `ctrl[0]` has no effect on the result.
- R4: Class 0 operators 0..4 are A*B (full 16-bit product), A/B, A+B, A-B and A%B. The subtraction is the 16-bit two's-complement difference, so 5-9 gives 16'hFFFC.
- R5: In class 0, divide (operator 1) and modulus (operator 4) with B equal to 0 give 16'h00FF.
- R6: These operations give 0 or 1 in bit 0 and zero above it. Class 1 operators 0..2 are !A, A&&B and A||B. Class 2 operators 0..3 are A>B, A<B, A>=B and A<=B. Class 3 operators 0..3 are A==B, A!=B, A==B and A!=B.
- R7: Class 4 operators 0..5 are ~A, A&B, A|B, A^B, A xnor B and A xnor B, each zero-extended. Operators 4 and 5 give identical results.
- R8: Class 5 operators 0..6 reduce A alone with AND, NAND, OR, NOR, XOR, XNOR and XNOR. The result is 1 bit, zero-extended.
- R9: Class 6 operator 0 gives A shifted right by B. Operator 1 gives A, zero-extended to 16 bits, shifted left by B, so bits carried into the upper byte are kept. Any shift of 16 or more gives 0.
- R10: Class 7 operator 0 gives {A,B}. Class 8 operator 0 gives {A,A}. Class 9 operator 0 gives B when A is nonzero and zero-extended C otherwise.
- R11: `parity` equals the XOR of all 16 bits of `result` after every update.
- R12: A class code above 9, or an operator code above the last one defined for its class, gives `result` 0 and `parity` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe; operands and control are sampled when high |
| ctrl | input | 8 | Control byte: class [7:4], operator [3:1], bit 0 unused |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| opc | input | 8 | Operand C (conditional select only) |
| out_valid | output | 1 | High for one cycle per issue, holding a new result |
| result | output | 16 | Registered result |
| parity | output | 1 | XOR of all result bits |

## Verification
Every result, its parity and the output valid are due one clock edge after the edge that samples `in_valid`. The bench drives inputs on the falling edge and lets one rising edge pass. It then reads `out_valid`, `result` and `parity` on the next falling edge, which sits exactly one register stage after the issue. For the hold behaviour the bench leaves the strobe low for several cycles while it changes the operands, and reads the outputs on each of those falling edges. Consecutive issues with different operator codes make sure no stale value can pass as a fresh one.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int CTRL_W  = 8;
    localparam int CLASS_W = 4;
    localparam int SEL_W   = 3;

    typedef enum logic [CLASS_W-1:0] {
        CL_ARITH = 4'd0,
        CL_LOGIC = 4'd1,
        CL_REL   = 4'd2,
        CL_EQ    = 4'd3,
        CL_BIT   = 4'd4,
        CL_RED   = 4'd5,
        CL_SHIFT = 4'd6,
        CL_CAT   = 4'd7,
        CL_REP   = 4'd8,
        CL_COND  = 4'd9
    } op_class_e;

    typedef struct packed {
        logic               known;
        op_class_e          cls;
        logic [SEL_W-1:0]   sel;
    } op_dec_t;

    // number of operator codes defined for a class (0 for undefined classes)
    function automatic int unsigned ops_in_class(logic [CLASS_W-1:0] c);
        case (c)
            4'd0:    return 5;
            4'd1:    return 3;
            4'd2:    return 4;
            4'd3:    return 4;
            4'd4:    return 6;
            4'd5:    return 7;
            4'd6:    return 2;
            4'd7, 4'd8, 4'd9: return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/alu_opdec.sv
module alu_opdec
    import alu_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output op_dec_t           dec
);
    logic [CLASS_W-1:0] cls_raw;
    logic [SEL_W-1:0]   sel_raw;

    assign cls_raw = ctrl[CTRL_W-1 -: CLASS_W];
    assign sel_raw = ctrl[SEL_W:1];

    always_comb begin
        dec.sel   = sel_raw;
        dec.known = (32'(sel_raw) < ops_in_class(cls_raw));
        dec.cls   = op_class_e'(cls_raw);
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int RES_W = 2 * DATA_W
) (
    input  op_dec_t           dec,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [RES_W-1:0]  res
);
    localparam logic [DATA_W-1:0] DIVZ_VAL = '1;

    logic [RES_W-1:0] wa, wb, wc;
    logic             b_zero, a_nz, b_nz;

    assign wa     = {{DATA_W{1'b0}}, a};
    assign wb     = {{DATA_W{1'b0}}, b};
    assign wc     = {{DATA_W{1'b0}}, c};
    assign b_zero = (b == '0);
    assign a_nz   = |a;
    assign b_nz   = |b;

    function automatic logic [RES_W-1:0] flag(logic f);
        return {{(RES_W-1){1'b0}}, f};
    endfunction

    always_comb begin
        res = '0;
        if (dec.known) begin
            unique case (dec.cls)
                CL_ARITH: case (dec.sel)
                    3'd0: res = wa * wb;
                    3'd1: res = b_zero ? {{DATA_W{1'b0}}, DIVZ_VAL} : wa / wb;
                    3'd2: res = wa + wb;
                    3'd3: res = wa - wb;
                    3'd4: res = b_zero ? {{DATA_W{1'b0}}, DIVZ_VAL} : wa % wb;
                    default: res = '0;
                endcase
                CL_LOGIC: case (dec.sel)
                    3'd0: res = flag(!a_nz);
                    3'd1: res = flag(a_nz && b_nz);
                    3'd2: res = flag(a_nz || b_nz);
                    default: res = '0;
                endcase
                CL_REL: case (dec.sel)
                    3'd0: res = flag(a > b);
                    3'd1: res = flag(a < b);
                    3'd2: res = flag(a >= b);
                    3'd3: res = flag(a <= b);
                    default: res = '0;
                endcase
                CL_EQ: res = flag(dec.sel[0] ? (a != b) : (a == b));
                CL_BIT: case (dec.sel)
                    3'd0: res = {{DATA_W{1'b0}}, ~a};
                    3'd1: res = {{DATA_W{1'b0}}, a & b};
                    3'd2: res = {{DATA_W{1'b0}}, a | b};
                    3'd3: res = {{DATA_W{1'b0}}, a ^ b};
                    3'd4, 3'd5: res = {{DATA_W{1'b0}}, ~(a ^ b)};
                    default: res = '0;
                endcase
                CL_RED: case (dec.sel)
                    3'd0: res = flag(&a);
                    3'd1: res = flag(~&a);
                    3'd2: res = flag(|a);
                    3'd3: res = flag(~|a);
                    3'd4: res = flag(^a);
                    3'd5, 3'd6: res = flag(~^a);
                    default: res = '0;
                endcase
                CL_SHIFT: res = dec.sel[0] ? (wa << b) : (wa >> b);
                CL_CAT:   res = {a, b};
                CL_REP:   res = {2{a}};
                CL_COND:  res = a_nz ? wb : wc;
                default:  res = '0;
            endcase
        end
    end
endmodule

// File: rtl/alu_parity.sv
module alu_parity #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] vec,
    output logic             par
);
    logic [WIDTH:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < WIDTH; i++) begin : g_fold
        assign chain[i+1] = chain[i] ^ vec[i];
    end
    assign par = chain[WIDTH];
endmodule

// File: rtl/alu_twolevel.sv
module alu_twolevel
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int RES_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] opc,
    output logic              out_valid,
    output logic [RES_W-1:0]  result,
    output logic              parity
);
    op_dec_t          dec;
    logic [RES_W-1:0] res_next;
    logic             par_next;

    alu_opdec u_dec (
        .ctrl (ctrl),
        .dec  (dec)
    );

    alu_exec #(.DATA_W(DATA_W)) u_exec (
        .dec (dec),
        .a   (opa),
        .b   (opb),
        .c   (opc),
        .res (res_next)
    );

    alu_parity #(.WIDTH(RES_W)) u_par (
        .vec (res_next),
        .par (par_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            parity    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_next;
                parity <= par_next;
            end
        end
    end
endmodule

// File: rtl/alu_twolevel_chk.sv
module alu_twolevel_chk #(
    parameter int DATA_W = 8,
    localparam int RES_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        ctrl,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic [RES_W-1:0]  result,
    input logic              parity
);
    // R2
    issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(parity)));
    // R5
    divzero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl[7:4] == 4'd0 && (ctrl[3:1] == 3'd1 || ctrl[3:1] == 3'd4) && opb == '0)
        |=> result == 16'h00FF);
    // R6
    flag_width_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (ctrl[7:4] == 4'd1 || ctrl[7:4] == 4'd2 || ctrl[7:4] == 4'd3 || ctrl[7:4] == 4'd5))
        |=> result[RES_W-1:1] == '0);
    // R11
    parity_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> parity == ^result);
    // R12
    bad_class_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl[7:4] > 4'd9) |=> (result == '0 && !parity));
endmodule

bind alu_twolevel alu_twolevel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .ctrl      (ctrl),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result),
    .parity    (parity)
);

// File: tb/tb_alu_twolevel.sv
`timescale 1ns/1ps
module tb_alu_twolevel;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  ctrl;
    logic [7:0]  opa, opb, opc;
    logic        out_valid;
    logic [15:0] result;
    logic        parity;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_twolevel dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
        .opa(opa), .opb(opb), .opc(opc),
        .out_valid(out_valid), .result(result), .parity(parity)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(logic [3:0] cls, logic [2:0] op);
        return {cls, op, 1'b0};
    endfunction

    // issue one operation at a falling edge, read it one register stage later
    task automatic issue(string tag, logic [7:0] c, logic [7:0] a, logic [7:0] b,
                         logic [7:0] cc, logic [15:0] exp);
        @(negedge clk);
        in_valid = 1'b1; ctrl = c; opa = a; opb = b; opc = cc;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "out_valid", {15'd0, out_valid}, 16'd1);
        check(tag, "result", result, exp);
        check("R11", "parity", {15'd0, parity}, {15'd0, ^exp});
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; ctrl = '0; opa = '0; opb = '0; opc = '0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid", {15'd0, out_valid}, 16'd0);
        check("R1", "result", result, 16'd0);
        check("R1", "parity", {15'd0, parity}, 16'd0);
        rst = 1'b0;
    endtask

    task automatic t_arith();
        issue("R4", mk(0, 0), 8'd200, 8'd150, 8'd0, 16'h7530);
        issue("R4", mk(0, 1), 8'd200, 8'd7,   8'd0, 16'd28);
        issue("R4", mk(0, 2), 8'd200, 8'd150, 8'd0, 16'd350);
        issue("R4", mk(0, 3), 8'd5,   8'd9,   8'd0, 16'hFFFC);
        issue("R4", mk(0, 4), 8'd200, 8'd7,   8'd0, 16'd4);
    endtask

    task automatic t_divzero();
        issue("R5", mk(0, 1), 8'd77, 8'd0, 8'd0, 16'h00FF);
        issue("R5", mk(0, 4), 8'd77, 8'd0, 8'd0, 16'h00FF);
    endtask

    task automatic t_ctrl_bit0();
        issue("R3", mk(0, 2) | 8'h01, 8'd200, 8'd150, 8'd0, 16'd350);
        issue("R3", mk(4, 1) | 8'h01, 8'hA5,  8'h0F,   8'd0, 16'h0005);
    endtask

    task automatic t_flags();
        issue("R6", mk(1, 0), 8'd0, 8'd0, 8'd0, 16'd1);
        issue("R6", mk(1, 1), 8'd3, 8'd0, 8'd0, 16'd0);
        issue("R6", mk(1, 2), 8'd0, 8'd5, 8'd0, 16'd1);
        issue("R6", mk(2, 0), 8'd9, 8'd3, 8'd0, 16'd1);
        issue("R6", mk(2, 1), 8'd9, 8'd3, 8'd0, 16'd0);
        issue("R6", mk(2, 2), 8'd7, 8'd7, 8'd0, 16'd1);
        issue("R6", mk(2, 3), 8'd8, 8'd7, 8'd0, 16'd0);
        issue("R6", mk(3, 0), 8'd4, 8'd4, 8'd0, 16'd1);
        issue("R6", mk(3, 1), 8'd4, 8'd4, 8'd0, 16'd0);
        issue("R6", mk(3, 2), 8'd4, 8'd5, 8'd0, 16'd0);
        issue("R6", mk(3, 3), 8'd4, 8'd5, 8'd0, 16'd1);
    endtask

    task automatic t_bitwise();
        issue("R7", mk(4, 0), 8'h0F, 8'h00, 8'd0, 16'h00F0);
        issue("R7", mk(4, 1), 8'hA5, 8'h0F, 8'd0, 16'h0005);
        issue("R7", mk(4, 2), 8'hA0, 8'h0F, 8'd0, 16'h00AF);
        issue("R7", mk(4, 3), 8'hFF, 8'h0F, 8'd0, 16'h00F0);
        issue("R7", mk(4, 4), 8'hA5, 8'h0F, 8'd0, 16'h0055);
        issue("R7", mk(4, 5), 8'hA5, 8'h0F, 8'd0, 16'h0055);
    endtask

    task automatic t_reduce();
        issue("R8", mk(5, 0), 8'hFF, 8'd0, 8'd0, 16'd1);
        issue("R8", mk(5, 1), 8'hFF, 8'd0, 8'd0, 16'd0);
        issue("R8", mk(5, 2), 8'h00, 8'd0, 8'd0, 16'd0);
        issue("R8", mk(5, 3), 8'h00, 8'd0, 8'd0, 16'd1);
        issue("R8", mk(5, 4), 8'h07, 8'd0, 8'd0, 16'd1);
        issue("R8", mk(5, 5), 8'h07, 8'd0, 8'd0, 16'd0);
        issue("R8", mk(5, 6), 8'h03, 8'd0, 8'd0, 16'd1);
    endtask

    task automatic t_shift();
        issue("R9", mk(6, 0), 8'h80, 8'd3,  8'd0, 16'h0010);
        issue("R9", mk(6, 1), 8'h81, 8'd4,  8'd0, 16'h0810);
        issue("R9", mk(6, 1), 8'hFF, 8'd8,  8'd0, 16'hFF00);
        issue("R9", mk(6, 1), 8'h01, 8'd16, 8'd0, 16'h0000);
        issue("R9", mk(6, 0), 8'hFF, 8'd9,  8'd0, 16'h0000);
    endtask

    task automatic t_pack();
        issue("R10", mk(7, 0), 8'h12, 8'h34, 8'h00, 16'h1234);
        issue("R10", mk(8, 0), 8'hAB, 8'h00, 8'h00, 16'hABAB);
        issue("R10", mk(9, 0), 8'h01, 8'h11, 8'h22, 16'h0011);
        issue("R10", mk(9, 0), 8'h00, 8'h11, 8'h22, 16'h0022);
    endtask

    task automatic t_undefined();
        issue("R12", mk(10, 0), 8'hFF, 8'hFF, 8'hFF, 16'h0000);
        issue("R10", mk(8, 0),  8'hAB, 8'h00, 8'h00, 16'hABAB);
        issue("R12", mk(0, 5),  8'hFF, 8'hFF, 8'hFF, 16'h0000);
        issue("R10", mk(8, 0),  8'h37, 8'h00, 8'h00, 16'h3737);
        issue("R12", mk(7, 1),  8'h12, 8'h34, 8'h00, 16'h0000);
        issue("R10", mk(7, 0),  8'h12, 8'h35, 8'h00, 16'h1235);
        issue("R12", mk(15, 7), 8'hFF, 8'hFF, 8'hFF, 16'h0000);
    endtask

    task automatic t_hold();
        issue("R2", mk(7, 0), 8'h5A, 8'hC3, 8'h00, 16'h5AC3);
        for (int k = 0; k < 3; k++) begin
            ctrl = mk(0, 2); opa = 8'(k); opb = 8'd1;
            @(negedge clk);
            check("R2", "idle out_valid", {15'd0, out_valid}, 16'd0);
            check("R2", "held result", result, 16'h5AC3);
            check("R2", "held parity", {15'd0, parity}, {15'd0, ^16'h5AC3});
        end
        // back-to-back issues each raise out_valid
        @(negedge clk);
        in_valid = 1'b1; ctrl = mk(0, 2); opa = 8'd1; opb = 8'd2;
        @(negedge clk);
        check("R2", "b2b first valid", {15'd0, out_valid}, 16'd1);
        check("R2", "b2b first", result, 16'd3);
        opa = 8'd10; opb = 8'd20;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "b2b second valid", {15'd0, out_valid}, 16'd1);
        check("R2", "b2b second", result, 16'd30);
        @(negedge clk);
        check("R2", "b2b drop", {15'd0, out_valid}, 16'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arith();
        t_divzero();
        t_ctrl_bit0();
        t_flags();
        t_bitwise();
        t_reduce();
        t_shift();
        t_pack();
        t_undefined();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule